// File: doc/BRIEF.md
# MMU Access Checker and Fault Recorder

This block sits between a processor's load, store and fetch path and the lookup port of a translation buffer. For every access it decides, from the privilege level and the address window, one of three routes:
- an identity mapping that needs no lookup;
- an immediate privilege fault for user accesses to the upper half of the address space;
- a lookup whose returned physical page and permission bits decide the result.

A failing real access reports a fault cause and updates three fault registers. These are a bad-address register, a data-versus-fetch flag and a page-table-entry address register. The entry address register keeps a software-written base field and takes the faulting page number into its page field. A second copy of that register records the last value the fault logic wrote.

A probe access reports only pass or fail and leaves every register alone. A debug access performs the lookup with no permission check and no side effects. It returns all ones when the lookup misses.

Control is a four-state machine:
- IDLE: ready for a request.
- ASK: the lookup request is driven.
- WAIT: the lookup answer is sampled.
- RESP: the result is presented for one cycle.

It moves through these transitions:
- IDLE to RESP when an accepted request needs no lookup.
- IDLE to ASK when an accepted request needs a lookup.
- ASK to WAIT.
- WAIT to RESP.
- RESP to IDLE.

Pages are 4 KB. Access kind encoding: 0 load, 1 store, 2 fetch. Permission bits from the lookup: bit 0 read, bit 1 write, bit 2 execute. Fault cause encoding:
- 0: none
- 1: privilege address fault
- 2: lookup miss
- 3: read denied
- 4: write denied
- 5: execute denied

Top module: `mmu_chk_top`

## Requirements
- R1: With `mmu_on` low, every accepted access returns `rsp_ok`=1, cause 0 and a physical address equal to the virtual address, one cycle after acceptance, without a lookup request.
- R2: A supervisor access (or a debug access) at or above 0xC0000000 with `mmu_on` high returns the identity mapping with `rsp_ok`=1 and cause 0, one cycle after acceptance, without a lookup request.
- R3: A non-debug user access at or above 0x80000000 with `mmu_on` high returns cause 1 and `rsp_ok`=0 one cycle after acceptance. It loads `bad_addr` with the virtual address and issues no lookup.
- R4: Every other access raises `lk_req` for exactly the cycle after acceptance, with `lk_vpn` = vaddr[31:12]. The answer is sampled in the following cycle, and `rsp_valid` comes three cycles after acceptance.
- R5: A lookup hit whose permission bit for the access kind is set returns `rsp_ok`=1, cause 0 and physical address {`lk_ppn`, vaddr[11:0]}.
- R6: A hit lacking the needed permission bit returns `rsp_ok`=0 and cause 3, 4 or 5 for a load, store or fetch respectively.
- R7: A lookup miss on a non-debug, non-probe access returns `rsp_ok`=0 and cause 2.
- R8: On a lookup fault (causes 2 to 5), `bad_addr` takes the virtual address and `tlb_dflag` becomes 0 for fetches and 1 for loads and stores.
- R9: On a lookup fault, `pte_addr` keeps bits [31:22], bits [21:2] take vaddr[31:12] and bits [1:0] are 0. `pte_last` takes the same new value.
- R10: A probe access that fails returns `rsp_ok`=0 and cause 0, and leaves `bad_addr`, `tlb_dflag`, `pte_addr` and `pte_last` unchanged.
- R11: A debug access never checks permissions. A hit returns `rsp_ok`=1 with the translated address, a miss returns `rsp_ok`=0 with all ones, the cause is 0 and no register changes.
- R12: After reset all four fault registers are 0. A `pt_base_wr` pulse loads `pte_addr`[31:22] from `pt_base` and keeps its other bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mmu_on | input | 1 | Translation configured |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Block is idle and accepts a request |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | 0 load, 1 store, 2 fetch |
| req_super | input | 1 | Supervisor privilege |
| req_probe | input | 1 | Probe: no fault, no register change |
| req_debug | input | 1 | Debug translate: no permission check, no side effects |
| lk_req | output | 1 | Lookup request |
| lk_vpn | output | 20 | Virtual page number to look up |
| lk_hit | input | 1 | Lookup hit, valid the cycle after `lk_req` |
| lk_ppn | input | 20 | Physical page number from the lookup |
| lk_perm | input | 3 | Execute, write, read permission bits |
| rsp_valid | output | 1 | Result valid |
| rsp_ok | output | 1 | Access succeeded |
| rsp_paddr | output | 32 | Physical address |
| rsp_cause | output | 3 | Fault cause code |
| pt_base_wr | input | 1 | Load base field of `pte_addr` |
| pt_base | input | 10 | New base field |
| bad_addr | output | 32 | Last faulting address |
| tlb_dflag | output | 1 | Last lookup fault was a data access |
| pte_addr | output | 32 | Page-table-entry address register |
| pte_last | output | 32 | Last value written to `pte_addr` by a fault |

## Verification
Direct-route results (R1 to R3) appear one cycle after the accepting edge. Lookup-route results appear three cycles after it. The fault registers change on the same edge that raises `rsp_valid`.

The bench counts edges from acceptance and compares that count with the latency the route implies. It drives the real lookup answer only in the cycle after it sees `lk_req` and drives inverted values in every other cycle. A design sampling the answer in the wrong cycle therefore produces a wrong result.

All outputs are read at the falling edge in the response cycle, and a sweep over privilege, mode, kind, address window, hit and every permission pattern compares them with arithmetic expectations.

// File: rtl/mmu_chk_pkg.sv
package mmu_chk_pkg;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    typedef enum logic [2:0] {
        FLT_NONE  = 3'd0,
        FLT_SUPER = 3'd1,
        FLT_MISS  = 3'd2,
        FLT_READ  = 3'd3,
        FLT_WRITE = 3'd4,
        FLT_EXEC  = 3'd5
    } fault_e;

    typedef enum logic [1:0] {
        RT_IDENT    = 2'd0,
        RT_SUPFAULT = 2'd1,
        RT_LOOKUP   = 2'd2
    } route_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ASK  = 2'd1,
        ST_WAIT = 2'd2,
        ST_RESP = 2'd3
    } state_e;

endpackage

// File: rtl/mmu_chk_classify.sv
module mmu_chk_classify
    import mmu_chk_pkg::*;
#(
    parameter int          AW   = 32,
    parameter logic [31:0] KWIN = 32'hC000_0000,
    parameter logic [31:0] UWIN = 32'h8000_0000
) (
    input  logic          mmu_on,
    input  logic          super_mode,
    input  logic          debug,
    input  logic [AW-1:0] vaddr,
    output route_e        route
);
    localparam logic [AW-1:0] KLIM = KWIN[AW-1:0];
    localparam logic [AW-1:0] ULIM = UWIN[AW-1:0];

    always_comb begin
        if (!mmu_on) begin
            route = RT_IDENT;
        end else if (super_mode || debug) begin
            route = (vaddr >= KLIM) ? RT_IDENT : RT_LOOKUP;
        end else begin
            route = (vaddr >= ULIM) ? RT_SUPFAULT : RT_LOOKUP;
        end
    end
endmodule

// File: rtl/mmu_chk_perm.sv
module mmu_chk_perm
    import mmu_chk_pkg::*;
#(
    parameter int AW        = 32,
    parameter int PAGE_BITS = 12,
    localparam int PNW      = AW - PAGE_BITS
) (
    input  acc_kind_e            kind,
    input  logic                 probe,
    input  logic                 debug,
    input  logic                 hit,
    input  logic [2:0]           perm,
    input  logic [PNW-1:0]       ppn,
    input  logic [PAGE_BITS-1:0] offs,
    output logic [AW-1:0]        paddr,
    output logic                 ok,
    output fault_e               cause,
    output logic                 raise
);
    logic   allowed;
    fault_e deny_code;

    always_comb begin
        unique case (kind)
            ACC_LOAD:  begin allowed = perm[0]; deny_code = FLT_READ;  end
            ACC_STORE: begin allowed = perm[1]; deny_code = FLT_WRITE; end
            default:   begin allowed = perm[2]; deny_code = FLT_EXEC;  end
        endcase
    end

    always_comb begin
        paddr = '0;
        ok    = 1'b0;
        cause = FLT_NONE;
        raise = 1'b0;
        if (debug) begin
            if (hit) begin
                paddr = {ppn, offs};
                ok    = 1'b1;
            end else begin
                paddr = '1;
            end
        end else if (hit && allowed) begin
            paddr = {ppn, offs};
            ok    = 1'b1;
        end else if (!probe) begin
            raise = 1'b1;
            cause = hit ? deny_code : FLT_MISS;
        end
    end
endmodule

// File: rtl/mmu_chk_regs.sv
module mmu_chk_regs #(
    parameter int AW        = 32,
    parameter int PAGE_BITS = 12,
    parameter int ENT_BITS  = 2,
    localparam int PNW      = AW - PAGE_BITS,
    localparam int BASEW    = AW - PNW - ENT_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             base_wr,
    input  logic [BASEW-1:0] base_val,
    input  logic             rec_bad,
    input  logic             rec_tlb,
    input  logic [AW-1:0]    vaddr,
    input  logic             is_fetch,
    output logic [AW-1:0]    bad_addr,
    output logic             tlb_dflag,
    output logic [AW-1:0]    pte_addr,
    output logic [AW-1:0]    pte_last
);
    logic [BASEW-1:0] base_next;
    logic [AW-1:0]    pte_fault_val;

    always_comb begin
        base_next     = base_wr ? base_val : pte_addr[AW-1 -: BASEW];
        pte_fault_val = {base_next, vaddr[AW-1:PAGE_BITS], {ENT_BITS{1'b0}}};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bad_addr  <= '0;
            tlb_dflag <= 1'b0;
            pte_addr  <= '0;
            pte_last  <= '0;
        end else begin
            if (rec_bad) begin
                bad_addr <= vaddr;
            end
            if (rec_tlb) begin
                tlb_dflag <= !is_fetch;
                pte_addr  <= pte_fault_val;
                pte_last  <= pte_fault_val;
            end else if (base_wr) begin
                pte_addr[AW-1 -: BASEW] <= base_val;
            end
        end
    end

    // R8
    dflag_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rec_tlb |=> (tlb_dflag == !$past(is_fetch)));

    // R9
    pte_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rec_tlb |=> (pte_last == pte_addr && pte_addr[ENT_BITS-1:0] == '0));
endmodule

// File: rtl/mmu_chk_top.sv
module mmu_chk_top
    import mmu_chk_pkg::*;
#(
    parameter int          AW        = 32,
    parameter int          PAGE_BITS = 12,
    parameter int          ENT_BITS  = 2,
    parameter logic [31:0] KWIN      = 32'hC000_0000,
    parameter logic [31:0] UWIN      = 32'h8000_0000,
    localparam int         PNW       = AW - PAGE_BITS,
    localparam int         BASEW     = AW - PNW - ENT_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mmu_on,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [AW-1:0]    req_vaddr,
    input  logic [1:0]       req_kind,
    input  logic             req_super,
    input  logic             req_probe,
    input  logic             req_debug,
    output logic             lk_req,
    output logic [PNW-1:0]   lk_vpn,
    input  logic             lk_hit,
    input  logic [PNW-1:0]   lk_ppn,
    input  logic [2:0]       lk_perm,
    output logic             rsp_valid,
    output logic             rsp_ok,
    output logic [AW-1:0]    rsp_paddr,
    output logic [2:0]       rsp_cause,
    input  logic             pt_base_wr,
    input  logic [BASEW-1:0] pt_base,
    output logic [AW-1:0]    bad_addr,
    output logic             tlb_dflag,
    output logic [AW-1:0]    pte_addr,
    output logic [AW-1:0]    pte_last
);
    state_e    state, state_nx;
    route_e    route;
    logic      accept;
    logic [AW-1:0] q_vaddr;
    acc_kind_e q_kind;
    logic      q_probe, q_debug;

    logic [AW-1:0] chk_paddr;
    logic      chk_ok, chk_raise;
    fault_e    chk_cause;
    logic      rec_bad, rec_tlb;
    logic [AW-1:0] rec_vaddr;

    mmu_chk_classify #(.AW(AW), .KWIN(KWIN), .UWIN(UWIN)) u_class (
        .mmu_on     (mmu_on),
        .super_mode (req_super),
        .debug      (req_debug),
        .vaddr      (req_vaddr),
        .route      (route)
    );

    mmu_chk_perm #(.AW(AW), .PAGE_BITS(PAGE_BITS)) u_perm (
        .kind  (q_kind),
        .probe (q_probe),
        .debug (q_debug),
        .hit   (lk_hit),
        .perm  (lk_perm),
        .ppn   (lk_ppn),
        .offs  (q_vaddr[PAGE_BITS-1:0]),
        .paddr (chk_paddr),
        .ok    (chk_ok),
        .cause (chk_cause),
        .raise (chk_raise)
    );

    always_comb begin
        accept    = (state == ST_IDLE) && req_valid;
        req_ready = (state == ST_IDLE);
        lk_req    = (state == ST_ASK);
        lk_vpn    = q_vaddr[AW-1:PAGE_BITS];
        rsp_valid = (state == ST_RESP);
        rec_tlb   = (state == ST_WAIT) && chk_raise;
        rec_bad   = rec_tlb ||
                    (accept && route == RT_SUPFAULT && !req_probe);
        rec_vaddr = accept ? req_vaddr : q_vaddr;
    end

    mmu_chk_regs #(.AW(AW), .PAGE_BITS(PAGE_BITS), .ENT_BITS(ENT_BITS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .base_wr   (pt_base_wr),
        .base_val  (pt_base),
        .rec_bad   (rec_bad),
        .rec_tlb   (rec_tlb),
        .vaddr     (rec_vaddr),
        .is_fetch  (q_kind == ACC_FETCH),
        .bad_addr  (bad_addr),
        .tlb_dflag (tlb_dflag),
        .pte_addr  (pte_addr),
        .pte_last  (pte_last)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (accept) state_nx = (route == RT_LOOKUP) ? ST_ASK : ST_RESP;
            ST_ASK:  state_nx = ST_WAIT;
            ST_WAIT: state_nx = ST_RESP;
            ST_RESP: state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // request capture and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_vaddr   <= '0;
            q_kind    <= ACC_LOAD;
            q_probe   <= 1'b0;
            q_debug   <= 1'b0;
            rsp_ok    <= 1'b0;
            rsp_paddr <= '0;
            rsp_cause <= FLT_NONE;
        end else if (accept) begin
            q_vaddr <= req_vaddr;
            q_kind  <= acc_kind_e'(req_kind);
            q_probe <= req_probe;
            q_debug <= req_debug;
            unique case (route)
                RT_IDENT: begin
                    rsp_ok    <= 1'b1;
                    rsp_paddr <= req_vaddr;
                    rsp_cause <= FLT_NONE;
                end
                RT_SUPFAULT: begin
                    rsp_ok    <= 1'b0;
                    rsp_paddr <= '0;
                    rsp_cause <= req_probe ? FLT_NONE : FLT_SUPER;
                end
                default: begin
                    rsp_ok    <= 1'b0;
                    rsp_paddr <= '0;
                    rsp_cause <= FLT_NONE;
                end
            endcase
        end else if (state == ST_WAIT) begin
            rsp_ok    <= chk_ok;
            rsp_paddr <= chk_paddr;
            rsp_cause <= chk_cause;
        end
    end

    // R4
    lookup_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |-> ##2 rsp_valid);

    // R4
    lookup_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> !lk_req);

    // R1
    ident_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid && !mmu_on) |=>
            (rsp_valid && rsp_ok && rsp_paddr == $past(req_vaddr)));

    // R5
    ok_no_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ok) |-> (rsp_cause == FLT_NONE));

    // R10
    probe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && q_probe && !pt_base_wr) |=>
            ($stable(bad_addr) && $stable(pte_addr) && $stable(tlb_dflag)));

    // R12
    base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pt_base_wr |=> $stable(pte_addr[AW-1 -: BASEW]));
endmodule

// File: tb/tb_mmu_chk_top.sv
module tb_mmu_chk_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mmu_on = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_kind = '0;
    logic        req_super = 1'b0;
    logic        req_probe = 1'b0;
    logic        req_debug = 1'b0;
    logic        lk_req;
    logic [19:0] lk_vpn;
    logic        lk_hit = 1'b0;
    logic [19:0] lk_ppn = '0;
    logic [2:0]  lk_perm = '0;
    logic        rsp_valid, rsp_ok;
    logic [31:0] rsp_paddr;
    logic [2:0]  rsp_cause;
    logic        pt_base_wr = 1'b0;
    logic [9:0]  pt_base = '0;
    logic [31:0] bad_addr, pte_addr, pte_last;
    logic        tlb_dflag;

    int errors = 0;
    int checks = 0;

    logic [31:0] m_bad = '0;
    logic        m_dflag = 1'b0;
    logic [31:0] m_pte = '0;
    logic [31:0] m_last = '0;

    always #10 clk = ~clk;

    mmu_chk_top dut (
        .clk(clk), .rst_n(rst_n), .mmu_on(mmu_on),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_kind(req_kind), .req_super(req_super), .req_probe(req_probe),
        .req_debug(req_debug), .lk_req(lk_req), .lk_vpn(lk_vpn),
        .lk_hit(lk_hit), .lk_ppn(lk_ppn), .lk_perm(lk_perm),
        .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_paddr(rsp_paddr),
        .rsp_cause(rsp_cause), .pt_base_wr(pt_base_wr), .pt_base(pt_base),
        .bad_addr(bad_addr), .tlb_dflag(tlb_dflag), .pte_addr(pte_addr),
        .pte_last(pte_last)
    );

    task automatic chk(input bit good, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!good) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic check_regs(input string tag);
        chk({bad_addr, tlb_dflag} == {m_bad, m_dflag}, tag, "bad_addr/dflag",
            {31'b0, bad_addr, tlb_dflag}, {31'b0, m_bad, m_dflag});
        chk({pte_addr, pte_last} == {m_pte, m_last}, tag, "pte_addr/pte_last",
            {pte_addr, pte_last}, {m_pte, m_last});
    endtask

    task automatic load_base(input logic [9:0] b);
        @(negedge clk);
        pt_base_wr = 1'b1;
        pt_base    = b;
        @(negedge clk);
        pt_base_wr = 1'b0;
        m_pte[31:22] = b;
        // R12: base loaded, page field kept
        check_regs("R12");
    endtask

    task automatic run_one(input bit mmu, input bit sup, input int mode,
                           input logic [1:0] kind, input logic [31:0] va,
                           input bit hit, input logic [2:0] perm);
        bit          probe = (mode == 1);
        bit          dbg   = (mode == 2);
        bit          ident, supf, look, allowed, fault, saw;
        int          lat, n;
        logic [19:0] ppn;
        logic [31:0] e_pa;
        bit          e_ok;
        logic [2:0]  e_cause;
        string       rtag, gtag;

        ppn   = va[31:12] ^ 20'h5A5A5 ^ {17'b0, perm};
        ident = !mmu || ((sup || dbg) && va >= 32'hC000_0000);
        supf  = !ident && !dbg && !sup && va >= 32'h8000_0000;
        look  = !ident && !supf;
        lat   = look ? 3 : 1;
        allowed = (kind == 2'd0) ? perm[0] : (kind == 2'd1) ? perm[1] : perm[2];
        e_pa = 32'h0; e_ok = 1'b0; e_cause = 3'd0; fault = 1'b0;
        gtag = "R5";
        if (ident) begin
            e_pa = va; e_ok = 1'b1;
            rtag = !mmu ? "R1" : dbg ? "R11" : "R2";
        end else if (supf) begin
            rtag = probe ? "R10" : "R3";
            gtag = rtag;
            if (!probe) begin e_cause = 3'd1; m_bad = va; end
        end else if (dbg) begin
            rtag = "R11"; gtag = "R11";
            if (hit) begin e_pa = {ppn, va[11:0]}; e_ok = 1'b1; end
            else e_pa = 32'hFFFF_FFFF;
        end else if (hit && allowed) begin
            e_pa = {ppn, va[11:0]}; e_ok = 1'b1; rtag = "R5";
        end else if (probe) begin
            rtag = "R10"; gtag = "R10";
        end else begin
            fault = 1'b1;
            rtag  = hit ? "R6" : "R7";
            gtag  = "R9";
            e_cause = !hit ? 3'd2 : (kind == 2'd0) ? 3'd3 : (kind == 2'd1) ? 3'd4 : 3'd5;
        end
        if (fault) begin
            m_bad   = va;
            m_dflag = (kind != 2'd2);
            m_pte   = {m_pte[31:22], va[31:12], 2'b00};
            m_last  = m_pte;
        end

        @(negedge clk);
        mmu_on = mmu; req_super = sup; req_probe = probe; req_debug = dbg;
        req_kind = kind; req_vaddr = va; req_valid = 1'b1;
        lk_hit = ~hit; lk_ppn = ~ppn; lk_perm = ~perm;
        @(posedge clk);
        #1 req_valid = 1'b0;
        n = 0; saw = 1'b0;
        while (n < 8) begin
            @(negedge clk);
            n++;
            if (rsp_valid) break;
            if (saw) begin
                lk_hit = hit; lk_ppn = ppn; lk_perm = perm;
            end else begin
                lk_hit = ~hit; lk_ppn = ~ppn; lk_perm = ~perm;
            end
            saw = lk_req;
            if (lk_req) begin
                // R4: page number offered to the lookup
                chk(lk_vpn == va[31:12], "R4", "lk_vpn", {44'b0, lk_vpn}, {44'b0, va[31:12]});
            end
        end
        lk_hit = ~hit; lk_ppn = ~ppn; lk_perm = ~perm;
        chk(n == lat, look ? "R4" : rtag, "latency", 64'(n), 64'(lat));
        chk({rsp_paddr, rsp_ok, rsp_cause} == {e_pa, e_ok, e_cause}, rtag,
            "paddr/ok/cause", {28'b0, rsp_paddr, rsp_ok, rsp_cause},
            {28'b0, e_pa, e_ok, e_cause});
        if (fault) begin
            // R8: dflag and bad address on lookup faults
            chk({bad_addr, tlb_dflag} == {m_bad, m_dflag}, "R8", "bad_addr/dflag",
                {31'b0, bad_addr, tlb_dflag}, {31'b0, m_bad, m_dflag});
        end
        check_regs(gtag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog all-requirements actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        check_regs("R12");
        chk(req_ready && !rsp_valid && !lk_req, "R12", "idle after reset",
            {61'b0, req_ready, rsp_valid, lk_req}, 64'h4);
        load_base(10'h2AB);
        for (int m = 0; m < 2; m++) begin
            load_base(m == 0 ? 10'h2AB : 10'h155);
            for (int s = 0; s < 2; s++)
                for (int md = 0; md < 3; md++)
                    for (int k = 0; k < 3; k++)
                        for (int a = 0; a < 6; a++)
                            for (int h = 0; h < 2; h++)
                                for (int p = 0; p < 8; p++) begin
                                    logic [31:0] va;
                                    case (a)
                                        0: va = 32'h0001_2345;
                                        1: va = 32'h7FFF_F0AC;
                                        2: va = 32'h8000_1FFF;
                                        3: va = 32'hBFFF_E004;
                                        4: va = 32'hC000_3210;
                                        default: va = 32'hFFFF_FFFC;
                                    endcase
                                    run_one(m[0], s[0], md, 2'(k), va, h[0], 3'(p));
                                end
        end
        load_base(10'h3C1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule